// File: doc/BRIEF.md
# Speculative Version Store

This block is a small fully associative store for word versions written by speculative tasks. Every entry holds one data word together with its address and the numeric ID of the task that wrote it. A larger ID means a younger (successor) task. Stores create or update versions without touching memory. Loads resolve against the versions visible to the requesting task. A load that finds no suitable version is served by a combinational memory read port.

When a task becomes nonspeculative, a commit request drains all of that task's entries to a memory write port, one word per cycle. This is lazy version management: memory only ever receives committed data. A squash request discards every entry whose task ID is at or above a given ID. This undoes the offending task and all of its successors at once.

Stores stall while the store is full and no matching entry exists. Stores also stall during a drain and during a squash cycle.

Top module: `spec_ver_store`

## Requirements
- R1: After reset the store is empty. `stReady` is 1, `cmtBusy` is 0 and `memWrEn` is 0. Every load is served from memory, with `ldFromBuf` 0, `memRdEn` 1 and `ldData` equal to `memRdData`.
- R2: An accepted store (`stValid` and `stReady` both 1 at a rising edge) creates a version that holds its data and does not write memory. A later load by the same task to that address returns the data with `ldFromBuf` 1 and `memRdEn` 0.
- R3: A task holds at most one version per address. A repeated store by the same task to the same address overwrites that entry's data and does not take a new entry.
- R4: When the requesting task has no version of the address, a load returns the version from the largest task ID that is below the requesting ID and that holds a version of the address.
- R5: A version written by a task with a larger ID than the requesting task is never returned. If no version with an ID at or below the requesting ID exists, the load is served from memory.
- R6: Versions of the same address from different tasks coexist, and each load resolves among them independently.
- R7: A commit (`cmtValid` with `cmtBusy` 0 at a rising edge) raises `cmtBusy` from the next cycle. For a task with k entries, `cmtBusy` stays high for max(k,1) cycles. `memWrEn` is high in k of those cycles, each time with one of the task's address/data pairs. The drained entries then leave the store.
- R8: While `cmtBusy` is 1, a commit request is ignored and `stReady` is 0.
- R9: A squash (`sqValid` at a rising edge) removes every entry whose task ID is greater than or equal to `sqTask`, and keeps older entries. During a cycle with `sqValid` 1, `stReady` is 0 and no store is taken.
- R10: With all entries occupied, `stReady` is 0 for a store that needs a new entry and no store is taken. A store that matches an existing address and task still sees `stReady` 1. It overwrites that entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stValid | input | 1 | Store request |
| stTask | input | TASK_W | ID of the storing task |
| stAddr | input | ADDR_W | Store address |
| stData | input | DATA_W | Store data |
| stReady | output | 1 | Store can be taken this cycle |
| ldValid | input | 1 | Load request |
| ldTask | input | TASK_W | ID of the loading task |
| ldAddr | input | ADDR_W | Load address |
| ldData | output | DATA_W | Load result, combinational |
| ldFromBuf | output | 1 | Load result came from a buffered version |
| cmtValid | input | 1 | Commit request |
| cmtTask | input | TASK_W | ID of the committing task |
| cmtBusy | output | 1 | Drain in progress |
| sqValid | input | 1 | Squash request |
| sqTask | input | TASK_W | Oldest task ID to discard |
| memRdEn | output | 1 | Load falls through to memory |
| memRdAddr | output | ADDR_W | Memory read address |
| memRdData | input | DATA_W | Memory read data, combinational |
| memWrEn | output | 1 | Drain write strobe |
| memWrAddr | output | ADDR_W | Drain write address |
| memWrData | output | DATA_W | Drain write data |

## Verification
A corrupted entry (a wrong tag, a stale valid bit, or a duplicate version) shows up on the next load to that address. The symptom is a wrong `ldData` or `ldFromBuf`, in the same cycle as the load, because lookup is combinational. A fault in the drain shows up on the memory write port during the cycles after the commit: a missing, extra or wrong-task `memWrEn` pulse, or a `cmtBusy` length that does not match the entry count. A faulty squash or full-store decision shows up either on `stReady` in the same cycle, or one cycle later as a load that still finds a discarded version.

// File: rtl/svb_pkg.sv
package svb_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic storeEn;
    logic squashEn;
    logic drainPop;
  } svbStrobe_t;
endpackage

// File: rtl/svb_first_one.sv
module svb_first_one #(
  parameter int W = 8
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] grant
);
  logic found;
  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/svb_ctrl.sv
module svb_ctrl
  import svb_pkg::*;
#(
  parameter int TASK_W = 3,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stValid,
  input  logic              sqValid,
  input  logic              cmtValid,
  input  logic [TASK_W-1:0] cmtTask,
  input  logic [DEPTH-1:0]  stMatchVec,
  input  logic [DEPTH-1:0]  freeVec,
  input  logic [DEPTH-1:0]  drainVec,
  output logic              stReady,
  output logic              cmtBusy,
  output logic [TASK_W-1:0] drainTask,
  output svbStrobe_t        strobe,
  output logic [DEPTH-1:0]  wrSel,
  output logic [DEPTH-1:0]  popSel
);
  logic [DEPTH-1:0] freeOne;
  logic             matchAny;
  logic             drainMore;
  logic             busyQ;
  logic [TASK_W-1:0] drainTaskQ;

  svb_first_one #(.W(DEPTH)) freePick_i  (.req(freeVec),  .grant(freeOne));
  svb_first_one #(.W(DEPTH)) drainPick_i (.req(drainVec), .grant(popSel));

  assign matchAny  = |stMatchVec;
  assign drainMore = |(drainVec & (drainVec - 1'b1));

  assign stReady   = !busyQ && !sqValid && (matchAny || (|freeVec));
  assign wrSel     = matchAny ? stMatchVec : freeOne;
  assign cmtBusy   = busyQ;
  assign drainTask = drainTaskQ;

  always_comb begin
    strobe          = '0;
    strobe.storeEn  = stValid && stReady;
    strobe.squashEn = sqValid;
    strobe.drainPop = busyQ && (|drainVec);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ      <= 1'b0;
      drainTaskQ <= '0;
    end else if (busyQ) begin
      busyQ <= drainMore;
    end else if (cmtValid) begin
      busyQ      <= 1'b1;
      drainTaskQ <= cmtTask;
    end
  end

  // R7
  commit_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmtValid && !cmtBusy) |=> cmtBusy);

  // R8
  commit_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmtBusy && cmtValid) |=> $stable(drainTask));

  // R8
  no_store_in_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmtBusy |-> !strobe.storeEn);
endmodule

// File: rtl/svb_data.sv
module svb_data
  import svb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int TASK_W = 3,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  svbStrobe_t        strobe,
  input  logic [DEPTH-1:0]  wrSel,
  input  logic [DEPTH-1:0]  popSel,
  input  logic [TASK_W-1:0] stTask,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic [TASK_W-1:0] sqTask,
  input  logic [TASK_W-1:0] drainTask,
  input  logic              ldValid,
  input  logic [TASK_W-1:0] ldTask,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DEPTH-1:0]  stMatchVec,
  output logic [DEPTH-1:0]  freeVec,
  output logic [DEPTH-1:0]  drainVec,
  output logic [DATA_W-1:0] ldData,
  output logic              ldFromBuf,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData
);
  logic [DEPTH-1:0]  vld;
  logic [ADDR_W-1:0] addrQ [DEPTH];
  logic [TASK_W-1:0] taskQ [DEPTH];
  logic [DATA_W-1:0] dataQ [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        addrQ[i] <= '0;
        taskQ[i] <= '0;
        dataQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strobe.squashEn && vld[i] && (taskQ[i] >= sqTask)) begin
          vld[i] <= 1'b0;
        end else if (strobe.drainPop && popSel[i]) begin
          vld[i] <= 1'b0;
        end else if (strobe.storeEn && wrSel[i]) begin
          vld[i]   <= 1'b1;
          addrQ[i] <= stAddr;
          taskQ[i] <= stTask;
          dataQ[i] <= stData;
        end
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : gTag
      assign stMatchVec[g] = vld[g] && (addrQ[g] == stAddr) && (taskQ[g] == stTask);
      assign freeVec[g]    = !vld[g];
      assign drainVec[g]   = vld[g] && (taskQ[g] == drainTask);
    end
  endgenerate

  // closest visible version: largest task ID not above the requester
  logic              hit;
  logic [TASK_W-1:0] bestTask;
  logic [DATA_W-1:0] bestData;
  always_comb begin
    hit      = 1'b0;
    bestTask = '0;
    bestData = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && (addrQ[i] == ldAddr) && (taskQ[i] <= ldTask) &&
          (!hit || (taskQ[i] > bestTask))) begin
        hit      = 1'b1;
        bestTask = taskQ[i];
        bestData = dataQ[i];
      end
    end
  end

  assign ldFromBuf = ldValid && hit;
  assign memRdEn   = ldValid && !hit;
  assign ldData    = hit ? bestData : memRdData;

  always_comb begin
    memWrAddr = '0;
    memWrData = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (popSel[i]) begin
        memWrAddr = memWrAddr | addrQ[i];
        memWrData = memWrData | dataQ[i];
      end
    end
  end

  // checking state: duplicates and leftovers of a squash
  logic dupFound;
  always_comb begin
    dupFound = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      for (int j = i + 1; j < DEPTH; j++) begin
        if (vld[i] && vld[j] && (addrQ[i] == addrQ[j]) && (taskQ[i] == taskQ[j]))
          dupFound = 1'b1;
      end
    end
  end

  logic              sqSeen;
  logic [TASK_W-1:0] sqTaskQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sqSeen  <= 1'b0;
      sqTaskQ <= '0;
    end else begin
      sqSeen  <= strobe.squashEn;
      sqTaskQ <= sqTask;
    end
  end

  logic youngLeft;
  always_comb begin
    youngLeft = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (vld[i] && (taskQ[i] >= sqTaskQ)) youngLeft = 1'b1;
  end

  // R3
  one_version_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dupFound);

  // R9
  squash_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    sqSeen |-> !youngLeft);

  // R10
  store_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeEn |-> $onehot(wrSel & (stMatchVec | freeVec)));

  // R5
  visible_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldFromBuf |-> (bestTask <= ldTask));
endmodule

// File: rtl/spec_ver_store.sv
module spec_ver_store
  import svb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int TASK_W = 3,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stValid,
  input  logic [TASK_W-1:0] stTask,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  output logic              stReady,
  input  logic              ldValid,
  input  logic [TASK_W-1:0] ldTask,
  input  logic [ADDR_W-1:0] ldAddr,
  output logic [DATA_W-1:0] ldData,
  output logic              ldFromBuf,
  input  logic              cmtValid,
  input  logic [TASK_W-1:0] cmtTask,
  output logic              cmtBusy,
  input  logic              sqValid,
  input  logic [TASK_W-1:0] sqTask,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData
);
  svbStrobe_t        strobe;
  logic [DEPTH-1:0]  stMatchVec, freeVec, drainVec, wrSel, popSel;
  logic [TASK_W-1:0] drainTask;

  svb_ctrl #(.TASK_W(TASK_W), .DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .stValid(stValid), .sqValid(sqValid),
    .cmtValid(cmtValid), .cmtTask(cmtTask), .stMatchVec(stMatchVec),
    .freeVec(freeVec), .drainVec(drainVec), .stReady(stReady),
    .cmtBusy(cmtBusy), .drainTask(drainTask), .strobe(strobe),
    .wrSel(wrSel), .popSel(popSel)
  );

  svb_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TASK_W(TASK_W), .DEPTH(DEPTH)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrSel(wrSel), .popSel(popSel),
    .stTask(stTask), .stAddr(stAddr), .stData(stData), .sqTask(sqTask),
    .drainTask(drainTask), .ldValid(ldValid), .ldTask(ldTask), .ldAddr(ldAddr),
    .memRdData(memRdData), .stMatchVec(stMatchVec), .freeVec(freeVec),
    .drainVec(drainVec), .ldData(ldData), .ldFromBuf(ldFromBuf),
    .memRdEn(memRdEn), .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

  assign memRdAddr = ldAddr;
  assign memWrEn   = strobe.drainPop;
endmodule

// File: tb/spec_ver_store_tb_top.sv
module spec_ver_store_tb_top;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int TASK_W = 3;
  localparam int DEPTH  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stValid = 1'b0, ldValid = 1'b0, cmtValid = 1'b0, sqValid = 1'b0;
  logic [TASK_W-1:0] stTask = '0, ldTask = '0, cmtTask = '0, sqTask = '0;
  logic [ADDR_W-1:0] stAddr = '0, ldAddr = '0;
  logic [DATA_W-1:0] stData = '0;
  logic stReady, ldFromBuf, cmtBusy, memRdEn, memWrEn;
  logic [DATA_W-1:0] ldData, memRdData, memWrData;
  logic [ADDR_W-1:0] memRdAddr, memWrAddr;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  logic [DATA_W-1:0] mem [1 << ADDR_W];
  initial for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = DATA_W'(16'hC000 | i);
  assign memRdData = mem[memRdAddr];
  always @(posedge clk) if (memWrEn) mem[memWrAddr] <= memWrData;

  spec_ver_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TASK_W(TASK_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stTask(stTask), .stAddr(stAddr),
    .stData(stData), .stReady(stReady), .ldValid(ldValid), .ldTask(ldTask),
    .ldAddr(ldAddr), .ldData(ldData), .ldFromBuf(ldFromBuf), .cmtValid(cmtValid),
    .cmtTask(cmtTask), .cmtBusy(cmtBusy), .sqValid(sqValid), .sqTask(sqTask),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic doStore(int t, int a, int d);
    stValid = 1'b1; stTask = TASK_W'(t); stAddr = ADDR_W'(a); stData = DATA_W'(d);
    tick();
    stValid = 1'b0;
  endtask

  task automatic loadChk(string req, int t, int a, int expD, bit expBuf);
    ldValid = 1'b1; ldTask = TASK_W'(t); ldAddr = ADDR_W'(a);
    #9;
    chk(req, "ldData", 32'(ldData), 32'(expD));
    chk(req, "ldFromBuf", 32'(ldFromBuf), 32'(expBuf));
    chk(req, "memRdEn", 32'(memRdEn), 32'(!expBuf));
    tick();
    ldValid = 1'b0;
  endtask

  task automatic doSquash(int t);
    sqValid = 1'b1; sqTask = TASK_W'(t);
    tick();
    sqValid = 1'b0;
  endtask

  task automatic testReset();
    #9;
    chk("R1", "stReady", 32'(stReady), 1);
    chk("R1", "cmtBusy", 32'(cmtBusy), 0);
    chk("R1", "memWrEn", 32'(memWrEn), 0);
    tick();
    loadChk("R1", 0, 5, 16'hC005, 0);
  endtask

  task automatic testStoreLoad();
    doStore(2, 10, 16'h1111);
    loadChk("R2", 2, 10, 16'h1111, 1);
    chk("R2", "memory untouched", 32'(mem[10]), 32'hC00A);
    doStore(2, 10, 16'h2222);
    loadChk("R3", 2, 10, 16'h2222, 1);
  endtask

  task automatic testVersions();
    doStore(0, 10, 16'hAAAA);
    doStore(5, 10, 16'h5555);
    loadChk("R4", 3, 10, 16'h2222, 1);
    loadChk("R4", 4, 10, 16'h2222, 1);
    loadChk("R6", 5, 10, 16'h5555, 1);
    loadChk("R6", 7, 10, 16'h5555, 1);
    loadChk("R6", 1, 10, 16'hAAAA, 1);
    doStore(6, 20, 16'h6666);
    loadChk("R5", 3, 20, 16'hC014, 0);
    loadChk("R5", 5, 20, 16'hC014, 0);
  endtask

  task automatic testCommit();
    int writes;
    // single-entry commit of task 2, second request during drain ignored
    cmtValid = 1'b1; cmtTask = 3'd2;
    tick();
    cmtTask = 3'd5;
    #9;
    chk("R7", "cmtBusy", 32'(cmtBusy), 1);
    chk("R7", "memWrEn", 32'(memWrEn), 1);
    chk("R7", "memWrAddr", 32'(memWrAddr), 10);
    chk("R7", "memWrData", 32'(memWrData), 32'h2222);
    chk("R8", "stReady in drain", 32'(stReady), 0);
    tick();
    cmtValid = 1'b0;
    #9;
    chk("R8", "cmtBusy after ignored commit", 32'(cmtBusy), 0);
    chk("R7", "memory merged", 32'(mem[10]), 32'h2222);
    tick();
    loadChk("R8", 5, 10, 16'h5555, 1);
    loadChk("R7", 3, 10, 16'hAAAA, 1);
    // three-entry commit of task 0
    doStore(0, 11, 16'hA011);
    doStore(0, 12, 16'hA012);
    cmtValid = 1'b1; cmtTask = 3'd0;
    tick();
    cmtValid = 1'b0;
    writes = 0;
    for (int c = 0; c < 3; c++) begin
      #9;
      chk("R7", "cmtBusy during drain", 32'(cmtBusy), 1);
      if (memWrEn) writes++;
      tick();
    end
    #9;
    chk("R7", "drain write count", 32'(writes), 3);
    chk("R7", "cmtBusy end", 32'(cmtBusy), 0);
    tick();
    chk("R7", "mem10", 32'(mem[10]), 32'hAAAA);
    chk("R7", "mem11", 32'(mem[11]), 32'hA011);
    chk("R7", "mem12", 32'(mem[12]), 32'hA012);
    loadChk("R7", 1, 11, 16'hA011, 0);
    // empty commit: one busy cycle, no write
    cmtValid = 1'b1; cmtTask = 3'd7;
    tick();
    cmtValid = 1'b0;
    #9;
    chk("R7", "empty commit busy", 32'(cmtBusy), 1);
    chk("R7", "empty commit no write", 32'(memWrEn), 0);
    tick();
    #9;
    chk("R7", "empty commit done", 32'(cmtBusy), 0);
    tick();
  endtask

  task automatic testSquash();
    doStore(3, 30, 16'h3333);
    doStore(7, 31, 16'h7777);
    sqValid = 1'b1; sqTask = 3'd5;
    stValid = 1'b1; stTask = 3'd1; stAddr = 8'd40; stData = 16'h4040;
    #9;
    chk("R9", "stReady during squash", 32'(stReady), 0);
    tick();
    sqValid = 1'b0; stValid = 1'b0;
    loadChk("R9", 7, 10, 16'hAAAA, 0);
    loadChk("R9", 7, 20, 16'hC014, 0);
    loadChk("R9", 7, 31, 16'hC01F, 0);
    loadChk("R9", 3, 30, 16'h3333, 1);
    loadChk("R9", 1, 40, 16'hC028, 0);
  endtask

  task automatic testFull();
    doSquash(0);
    for (int i = 0; i < DEPTH; i++) doStore(1, 50 + i, 16'h5000 + i);
    stValid = 1'b1; stTask = 3'd1; stAddr = 8'd60; stData = 16'hDEAD;
    #9;
    chk("R10", "stReady full new addr", 32'(stReady), 0);
    tick();
    stAddr = 8'd53; stData = 16'hBEEF;
    #9;
    chk("R10", "stReady full match", 32'(stReady), 1);
    tick();
    stValid = 1'b0;
    loadChk("R10", 1, 53, 16'hBEEF, 1);
    loadChk("R10", 1, 60, 16'hC03C, 0);
    loadChk("R10", 1, 57, 16'h5007, 1);
    doSquash(1);
    #9;
    chk("R10", "stReady after free", 32'(stReady), 1);
    tick();
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick();
    testReset();
    testStoreLoad();
    testVersions();
    testCommit();
    testSquash();
    testFull();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule